// File: doc/BRIEF.md
# Machine Trap Entry and Return Controller

This block computes the architectural side effects of a trap. The caller presents one event at a time: a synchronous exception with a 5-bit cause code, a request to test for and take a pending interrupt, or a machine-mode return. The block also receives the current privilege level, the status word, the interrupt enable and pending masks, the trap vector register, the faulting PC and the saved exception PC. It then produces the new privilege level, the new status word, the cause and exception-PC values to write back, and the PC to redirect fetch to.

The controller is a three-state machine. In `ST_IDLE` it accepts an event. From there the transition `idle_to_entry` leads to `ST_ENTRY` when an exception or an interrupt is taken, and the transition `idle_to_return` leads to `ST_RETURN` for a machine return. Both reporting states last exactly one cycle, and the transition `report_to_idle` always leads back to `ST_IDLE`. While the machine is in a reporting state, `out_valid` is high and the registered results are stable. The results are written to the output registers on the clock edge that accepts the event.

The privilege level is encoded as 0 for user and 3 for machine. Status bit 3 is the global interrupt enable. Bit 7 holds the previous enable. Bits 12:11 hold the previous privilege. Bit 17 is the modify-privilege flag.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, `out_valid` is 0, `out_priv` is 3 and `out_status`, `out_cause`, `out_epc` and `out_target` are all zero.
- R2: An exception accepted at a clock edge gives exactly one cycle with `out_valid`=1 and `out_entry`=1, starting from the next cycle. During that cycle `out_priv`=3, `out_cause`={1'b0, 26'b0, exc_code} and `out_epc`=`trap_pc`.
- R3: On any trap entry, status bits 12:11 take the prior privilege level, bit 7 takes the prior value of bit 3, and bit 3 becomes 0. All other status bits pass through unchanged.
- R4: An interrupt check is taken only when (irq_pending & irq_enable) is non-zero and either status bit 3 is 1 or `cur_priv` is not 3. Otherwise no result is produced.
- R5: A taken interrupt reports `out_cause` with bit 31 set and bits 4:0 equal to the index of the lowest set bit of (irq_pending & irq_enable). `out_epc` is `trap_pc`.
- R6: The trap target is `vec_base` with bit 0 cleared, for every exception and for every interrupt when `vec_base` bit 0 is 0.
- R7: When `vec_base` bit 0 is 1 and an interrupt is taken, the target is that cleared base plus 4 times the interrupt index.
- R8: On a return, `out_priv` equals the prior status bits 12:11. The new status has bits 12:11 at 0, bit 3 equal to the prior bit 7, and bit 7 at 0.
- R9: On a return, status bit 17 is cleared when the restored privilege is not 3 and kept when it is 3. `out_entry` is 0 and `out_target` equals `ret_pc`.
- R10: Requests that are present during a reporting cycle are ignored, so each accepted event gives exactly one result pulse.
- R11: An exception request is held off, with no result, while `csr_wr_pending` is 1. It is accepted in the first idle cycle after `csr_wr_pending` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_priv | input | 2 | Current privilege level (0 user, 3 machine) |
| status_in | input | 32 | Current status word |
| irq_enable | input | 32 | Interrupt enable mask |
| irq_pending | input | 32 | Effective interrupt pending mask |
| vec_base | input | 32 | Trap vector register; bit 0 selects vectored interrupts |
| exc_req | input | 1 | Exception request |
| exc_code | input | 5 | Exception cause code |
| trap_pc | input | 32 | PC of the trapping instruction |
| irq_chk | input | 1 | Request to take a pending interrupt if allowed |
| ret_req | input | 1 | Machine return request |
| ret_pc | input | 32 | Saved exception PC used as the return target |
| csr_wr_pending | input | 1 | A register write is still outstanding |
| out_valid | output | 1 | Result cycle |
| out_entry | output | 1 | 1 for trap entry, 0 for return |
| out_priv | output | 2 | New privilege level |
| out_status | output | 32 | New status word |
| out_cause | output | 32 | Cause value to store (meaningful on entry) |
| out_epc | output | 32 | Exception PC to store (meaningful on entry) |
| out_target | output | 32 | Redirect PC |

## Verification
The hardest situation to create is a request that arrives while a result is being reported. The stimulus holds `exc_req` across both the accepting edge and the reporting edge, then expects a single scoreboard entry. The exception hold-off needs a second signal kept high for several idle cycles: `csr_wr_pending` is raised alongside the request, and an early result shows up as an item that the scoreboard does not expect. Interrupt refusals are checked in the same way, because any result pulse in those windows is reported as unexpected.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int ST_GIE_BIT  = 3;
    localparam int ST_PGIE_BIT = 7;
    localparam int ST_PPL_LO   = 11;
    localparam int ST_PPL_HI   = 12;
    localparam int ST_MODP_BIT = 17;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_RETURN = 2'd2
    } trap_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_IRQ  = 2'd2,
        EV_RET  = 2'd3
    } trap_event_e;

endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
    parameter int XLEN = 32,
    localparam int CODE_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]   pending,
    input  logic [XLEN-1:0]   enable,
    output logic              any,
    output logic [CODE_W-1:0] idx
);
    logic [XLEN-1:0] hit;
    logic [XLEN-1:0] first;
    logic [XLEN:0]   seen;

    assign hit     = pending & enable;
    assign seen[0] = 1'b0;

    // Prefix chain: a bit is the winner when no lower bit is set.
    for (genvar i = 0; i < XLEN; i++) begin : g_chain
        assign seen[i+1] = seen[i] | hit[i];
        assign first[i]  = hit[i] & ~seen[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (first[i]) idx = idx | CODE_W'(i);
        end
    end

    assign any = seen[XLEN];
endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd #(
    parameter int XLEN = 32
) (
    input  logic [1:0]      cur_priv,
    input  logic [XLEN-1:0] status_in,
    output logic [XLEN-1:0] entry_status,
    output logic [XLEN-1:0] ret_status,
    output logic [1:0]      ret_priv
);
    import trap_pkg::*;

    always_comb begin
        entry_status                       = status_in;
        entry_status[ST_PPL_HI:ST_PPL_LO]  = cur_priv;
        entry_status[ST_PGIE_BIT]          = status_in[ST_GIE_BIT];
        entry_status[ST_GIE_BIT]           = 1'b0;
    end

    always_comb begin
        ret_priv                         = status_in[ST_PPL_HI:ST_PPL_LO];
        ret_status                       = status_in;
        ret_status[ST_PPL_HI:ST_PPL_LO]  = PRIV_U;
        if (ret_priv != PRIV_M) ret_status[ST_MODP_BIT] = 1'b0;
        ret_status[ST_GIE_BIT]           = status_in[ST_PGIE_BIT];
        ret_status[ST_PGIE_BIT]          = 1'b0;
    end
endmodule

// File: rtl/trap_target.sv
module trap_target #(
    parameter int XLEN = 32,
    localparam int CODE_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]   vec_base,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   target
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    assign base   = {vec_base[XLEN-1:1], 1'b0};
    assign offset = XLEN'(code) << 2;
    assign target = (vec_base[0] && is_irq) ? (base + offset) : base;
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
    parameter int XLEN = 32,
    localparam int CODE_W = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cur_priv,
    input  logic [XLEN-1:0]   status_in,
    input  logic [XLEN-1:0]   irq_enable,
    input  logic [XLEN-1:0]   irq_pending,
    input  logic [XLEN-1:0]   vec_base,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic              irq_chk,
    input  logic              ret_req,
    input  logic [XLEN-1:0]   ret_pc,
    input  logic              csr_wr_pending,
    output logic              out_valid,
    output logic              out_entry,
    output logic [1:0]        out_priv,
    output logic [XLEN-1:0]   out_status,
    output logic [XLEN-1:0]   out_cause,
    output logic [XLEN-1:0]   out_epc,
    output logic [XLEN-1:0]   out_target
);
    import trap_pkg::*;

    trap_state_e       state, state_nxt;
    trap_event_e       ev;
    logic              irq_any, irq_ok, is_irq, accept;
    logic [CODE_W-1:0] irq_idx, code;
    logic [XLEN-1:0]   cause_full, tgt;
    logic [XLEN-1:0]   entry_status, ret_status;
    logic [1:0]        ret_priv;

    trap_irq_pick #(.XLEN(XLEN)) u_pick (
        .pending (irq_pending),
        .enable  (irq_enable),
        .any     (irq_any),
        .idx     (irq_idx)
    );

    assign irq_ok = irq_any && (status_in[ST_GIE_BIT] || (cur_priv != PRIV_M));

    // Event decode; the caller presents one event at a time.
    always_comb begin
        if (ret_req)                  ev = EV_RET;
        else if (exc_req)             ev = csr_wr_pending ? EV_NONE : EV_EXC;
        else if (irq_chk && irq_ok)   ev = EV_IRQ;
        else                          ev = EV_NONE;
    end

    assign accept     = (state == ST_IDLE) && (ev != EV_NONE);
    assign is_irq     = (ev == EV_IRQ);
    assign code       = is_irq ? irq_idx : exc_code;
    assign cause_full = {is_irq, {(XLEN-1-CODE_W){1'b0}}, code};

    trap_status_upd #(.XLEN(XLEN)) u_status (
        .cur_priv     (cur_priv),
        .status_in    (status_in),
        .entry_status (entry_status),
        .ret_status   (ret_status),
        .ret_priv     (ret_priv)
    );

    trap_target #(.XLEN(XLEN)) u_target (
        .vec_base (vec_base),
        .is_irq   (is_irq),
        .code     (code),
        .target   (tgt)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                unique case (ev)
                    EV_EXC, EV_IRQ: state_nxt = ST_ENTRY;   // idle_to_entry
                    EV_RET:         state_nxt = ST_RETURN;  // idle_to_return
                    default:        state_nxt = ST_IDLE;
                endcase
            end
            ST_ENTRY, ST_RETURN: state_nxt = ST_IDLE;        // report_to_idle
            default:             state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Result registers, written on the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_priv   <= PRIV_M;
            out_status <= '0;
            out_cause  <= '0;
            out_epc    <= '0;
            out_target <= '0;
        end else if (accept) begin
            unique case (ev)
                EV_EXC, EV_IRQ: begin
                    out_priv   <= PRIV_M;
                    out_status <= entry_status;
                    out_cause  <= cause_full;
                    out_epc    <= trap_pc;
                    out_target <= tgt;
                end
                EV_RET: begin
                    out_priv   <= ret_priv;
                    out_status <= ret_status;
                    out_target <= ret_pc;
                end
                default: ;
            endcase
        end
    end

    assign out_valid = (state != ST_IDLE);
    assign out_entry = (state == ST_ENTRY);

    // R2
    exc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ev == EV_EXC) |=>
            (out_valid && out_entry && out_epc == $past(trap_pc) && out_priv == PRIV_M));

    // R3
    entry_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && (ev == EV_EXC || ev == EV_IRQ)) |=>
            (out_status[ST_PGIE_BIT] == $past(status_in[ST_GIE_BIT]) && !out_status[ST_GIE_BIT]));

    // R5
    lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (irq_pending[irq_idx] && irq_enable[irq_idx] &&
                     (((irq_pending & irq_enable) & ((XLEN'(1) << irq_idx) - XLEN'(1))) == '0)));

    // R9
    ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ev == EV_RET) |=> (!out_entry && out_valid && out_target == $past(ret_pc)));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R11
    holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && exc_req && csr_wr_pending && !ret_req) |=> !out_valid);
endmodule

// File: tb/trap_ctrl_tb.sv
`timescale 1ns/1ps
module trap_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_priv = 2'd3;
    logic [31:0] status_in = '0, irq_enable = '0, irq_pending = '0, vec_base = '0;
    logic        exc_req = 1'b0, irq_chk = 1'b0, ret_req = 1'b0, csr_wr_pending = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] trap_pc = '0, ret_pc = '0;
    logic        out_valid, out_entry;
    logic [1:0]  out_priv;
    logic [31:0] out_status, out_cause, out_epc, out_target;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic        entry;
        logic [1:0]  priv;
        logic [31:0] status, cause, epc, target;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    trap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .status_in(status_in),
        .irq_enable(irq_enable), .irq_pending(irq_pending), .vec_base(vec_base),
        .exc_req(exc_req), .exc_code(exc_code), .trap_pc(trap_pc), .irq_chk(irq_chk),
        .ret_req(ret_req), .ret_pc(ret_pc), .csr_wr_pending(csr_wr_pending),
        .out_valid(out_valid), .out_entry(out_entry), .out_priv(out_priv),
        .out_status(out_status), .out_cause(out_cause), .out_epc(out_epc),
        .out_target(out_target)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model_entry(logic [1:0] p, logic [31:0] st, logic irq,
                                         logic [4:0] c, logic [31:0] vec, logic [31:0] pc,
                                         string tag);
        exp_t e;
        logic [31:0] base;
        e.entry = 1'b1;
        e.priv = 2'd3;
        e.status = st;
        e.status[12:11] = p;
        e.status[7] = st[3];
        e.status[3] = 1'b0;
        e.cause = {irq, 26'b0, c};
        e.epc = pc;
        base = vec & 32'hFFFF_FFFE;
        e.target = (irq && vec[0]) ? base + 32'(c) * 32'd4 : base;
        e.tag = tag;
        return e;
    endfunction

    function automatic exp_t model_ret(logic [31:0] st, logic [31:0] rpc, string tag);
        exp_t e;
        e.entry = 1'b0;
        e.priv = st[12:11];
        e.status = st;
        e.status[12:11] = 2'd0;
        if (st[12:11] != 2'd3) e.status[17] = 1'b0;
        e.status[3] = st[7];
        e.status[7] = 1'b0;
        e.cause = '0;
        e.epc = '0;
        e.target = rpc;
        e.tag = tag;
        return e;
    endfunction

    // Monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10 unexpected result: actual=valid expected=none (target=%h)", out_target);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "entry", 32'(out_entry), 32'(e.entry));
                check(e.tag, "priv", 32'(out_priv), 32'(e.priv));
                check(e.tag, "status", out_status, e.status);
                check(e.tag, "target", out_target, e.target);
                if (e.entry) begin
                    check(e.tag, "cause", out_cause, e.cause);
                    check(e.tag, "epc", out_epc, e.epc);
                end
            end
        end
    end

    task automatic gap(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_exc(logic [1:0] p, logic [31:0] st, logic [31:0] vec,
                          logic [4:0] c, logic [31:0] pc, string tag);
        @(negedge clk);
        cur_priv = p; status_in = st; vec_base = vec; exc_code = c; trap_pc = pc;
        exc_req = 1'b1;
        q.push_back(model_entry(p, st, 1'b0, c, vec, pc, tag));
        @(negedge clk);
        exc_req = 1'b0;
        gap(2);
    endtask

    task automatic do_irq(logic [1:0] p, logic [31:0] st, logic [31:0] ie, logic [31:0] ip,
                          logic [31:0] vec, logic [31:0] pc, logic take, string tag);
        logic [4:0] idx;
        logic [31:0] m;
        m = ie & ip;
        idx = '0;
        for (int i = 31; i >= 0; i--) if (m[i]) idx = 5'(i);
        @(negedge clk);
        cur_priv = p; status_in = st; irq_enable = ie; irq_pending = ip;
        vec_base = vec; trap_pc = pc; irq_chk = 1'b1;
        if (take) q.push_back(model_entry(p, st, 1'b1, idx, vec, pc, tag));
        @(negedge clk);
        irq_chk = 1'b0;
        gap(2);
    endtask

    task automatic do_ret(logic [31:0] st, logic [31:0] rpc, string tag);
        @(negedge clk);
        status_in = st; ret_pc = rpc; ret_req = 1'b1;
        q.push_back(model_ret(st, rpc, tag));
        @(negedge clk);
        ret_req = 1'b0;
        gap(2);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        gap(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "valid", 32'(out_valid), 32'd0);
        check("R1", "priv", 32'(out_priv), 32'd3);
        check("R1", "status", out_status, 32'd0);
        check("R1", "cause", out_cause, 32'd0);
        check("R1", "epc", out_epc, 32'd0);
        check("R1", "target", out_target, 32'd0);

        // R2 R3 R6: exception from user, vectored bit must not apply
        do_exc(2'd0, 32'h8000_0008, 32'h2000_0101, 5'd11, 32'h0000_4444, "R2/R3/R6");
        // R3: exception from machine, enable clear, previous enable was set
        do_exc(2'd3, 32'h0000_1880, 32'h0000_3000, 5'd2, 32'h0000_0100, "R3");
        // R4 R5 R7: vectored interrupt, lowest of pending&enable is 7
        do_irq(2'd3, 32'h0000_0008, 32'h0000_0888, 32'h0000_0880, 32'h1000_0001,
               32'h0000_5000, 1'b1, "R5/R7");
        // R6: non-vectored interrupt uses base
        do_irq(2'd3, 32'h0000_0008, 32'h0000_0800, 32'hFFFF_0800, 32'h1000_0000,
               32'h0000_6000, 1'b1, "R6");
        // R4: global enable clear in machine mode, no result
        do_irq(2'd3, 32'h0000_0000, 32'h0000_0080, 32'h0000_0080, 32'h1000_0001,
               32'h0, 1'b0, "R4");
        // R4: global enable clear but user mode, taken; bit 31 index
        do_irq(2'd0, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 32'h1000_0001,
               32'h0000_7000, 1'b1, "R4/R5");
        // R4: nothing both pending and enabled
        do_irq(2'd0, 32'h0000_0008, 32'h0000_00F0, 32'h0000_0F00, 32'h0,
               32'h0, 1'b0, "R4");
        // R8 R9: return to user, modify-privilege cleared
        do_ret(32'h0002_0080, 32'h0000_ABC0, "R8/R9");
        // R8 R9: return to machine, modify-privilege kept
        do_ret(32'h0002_1800, 32'h0000_DEF0, "R8/R9");

        // R11: exception held off while a write is pending
        @(negedge clk);
        cur_priv = 2'd0; status_in = 32'h0000_0008; vec_base = 32'h0000_0800;
        exc_code = 5'd5; trap_pc = 32'h0000_0900;
        exc_req = 1'b1; csr_wr_pending = 1'b1;
        gap(3);
        csr_wr_pending = 1'b0;
        q.push_back(model_entry(2'd0, 32'h0000_0008, 1'b0, 5'd5, 32'h0000_0800,
                                32'h0000_0900, "R11"));
        @(negedge clk);
        exc_req = 1'b0;
        gap(2);

        // R10: request held through the reporting cycle yields one result
        @(negedge clk);
        cur_priv = 2'd3; status_in = 32'h0000_0000; vec_base = 32'h0000_0C00;
        exc_code = 5'd31; trap_pc = 32'h0000_0A00;
        exc_req = 1'b1;
        q.push_back(model_entry(2'd3, 32'h0, 1'b0, 5'd31, 32'h0000_0C00,
                                32'h0000_0A00, "R10"));
        gap(2);
        exc_req = 1'b0;
        gap(4);

        check("R10", "queue empty", 32'(q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule